// File: doc/BRIEF.md
# Output fault retry supervisor

This block decides when the main power output is allowed to run. It watches four fault flags from external comparators (overvoltage, overtemperature, undervoltage and overcurrent), a flag saying the output sits inside its regulation band, an active-low enable request and a flag saying input power is present. Every delay is counted in periods of a millisecond tick strobe, and every delay is a parameter in tick units. This lets a testbench shrink the delays to a few ticks.

When the output is requested, it switches on after a turn-on delay. When the request is withdrawn, it switches off after a short hold. A fault shuts the output down at once, holds it off for a long cool-down and then restarts it without any help from outside. There is a limited budget of automatic restarts. The first fault after that budget is spent locks the output off until input power is lost or the enable request is toggled.

A static overcurrent only counts once it has stayed asserted for a blanking window. An undervoltage only counts after the output has reached regulation in the current run, so the ramp-up is not taken for a fault. The active-low power-good output has a long qualification delay on assertion, a short filter on loss of regulation, and is forced high whenever the output is not running.

Top module: `rail_retry_supervisor`

## Requirements
- R1: After reset, out_en is 0, pgood_n is 1 and fault_latched is 0.
- R2: With src_ok high and en_n low, out_en goes to 1 on the ON_DLY_TICKS-th ms_tick after the request. Raising en_n before then cancels the request, and a new request restarts the full delay.
- R3: Raising en_n while the output runs keeps out_en at 1 for EN_OFF_TICKS ticks, then drives it to 0.
- R4: While out_en is 1, an asserted flt_ov or flt_ot, a qualified overcurrent or a qualified undervoltage drives out_en to 0 on the next clock edge.
- R5: After a fault shutdown that is not the last allowed, out_en stays 0 for OFF_TICKS ticks and returns to 1 on the OFF_TICKS-th tick with no change of en_n.
- R6: After MAX_RETRY automatic restarts, the next fault sets fault_latched to 1 and holds out_en at 0 for as long as src_ok stays high and en_n stays low.
- R7: Setting en_n high, or src_ok low, clears fault_latched and the restart count, so that a full MAX_RETRY restarts are again available.
- R8: flt_oc shuts the output down only after it has stayed high for OC_BLANK_TICKS ticks while the output runs. A shorter pulse neither stops the output nor uses up a restart.
- R9: flt_uv is ignored in a run until in_reg has been seen high during that run.
- R10: pgood_n goes to 0 on the PG_ON_TICKS-th tick of in_reg held high while the output runs.
- R11: Once pgood_n is 0, it returns to 1 on the PG_OFF_TICKS-th tick of in_reg held low. If in_reg returns high before then, the loss count starts again.
- R12: pgood_n is 1 whenever the output is not in its running state: in standby, during the turn-on or turn-off delay, during cool-down and while latched.
- R13: src_ok low drives out_en to 0 on the next clock edge, whatever the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle strobe each delay unit (nominally 1 ms) |
| en_n | input | 1 | Output enable request, active low |
| src_ok | input | 1 | Input power present |
| flt_ov | input | 1 | Output overvoltage flag |
| flt_oc | input | 1 | Static overcurrent flag (unqualified) |
| flt_uv | input | 1 | Output below undervoltage limit (under 93 % of nominal) |
| flt_ot | input | 1 | Overtemperature flag |
| in_reg | input | 1 | Output inside its regulation band |
| out_en | output | 1 | Enable for the main output power stage |
| pgood_n | output | 1 | Power good, active low |
| fault_latched | output | 1 | Output locked off after too many faults |

## Verification
The hardest state to reach from the ports is the lock-off. It needs exactly MAX_RETRY complete fault, cool-down and restart cycles, with nothing that clears the restart count in between. The stimulus therefore walks a table of fault kinds (overvoltage, overtemperature, armed undervoltage and fully blanked overcurrent) and waits out each cool-down tick by tick. A short overcurrent pulse comes first, so that locking off on the sixth real fault, and not the fifth, shows that the pulse used up no restart. The walk is run twice, cleared once by loss of input power and once by an enable toggle, to show that both clear paths restore the full restart budget.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ONDLY  = 3'd1,
      ST_RUN    = 3'd2,
      ST_OFFDLY = 3'd3,
      ST_COOL   = 3'd4,
      ST_LATCH  = 3'd5
   } rrs_state_e;

   // bits needed to hold values 0..max_val
   function automatic int unsigned cnt_w(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/rrs_tick_count.sv
// Counts strobes up to limit-1 and flags the strobe that completes the span.
module rrs_tick_count #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         tick,
   input  logic [W-1:0] limit,
   output logic         done
);
   timeunit 1ns;
   timeprecision 1ps;

   generate
      if (W < 1) begin : g_bad_w
         $error("rrs_tick_count: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;
   logic         at_last;

   assign at_last = (cnt_q == (limit - W'(1)));
   assign done    = tick & at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr)            cnt_q <= '0;
      else if (tick && !at_last) cnt_q <= cnt_q + W'(1);
   end
endmodule

// File: rtl/rrs_oc_blank.sv
// Qualifies the static overcurrent flag with a blanking window.
module rrs_oc_blank #(
   parameter int unsigned BLANK_TICKS = 22
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic arm,
   input  logic flt_oc,
   output logic trip
);
   timeunit 1ns;
   timeprecision 1ps;

   generate
      if (BLANK_TICKS == 0) begin : g_direct
         assign trip = arm & flt_oc;
      end else begin : g_timed
         localparam int unsigned W = rrs_pkg::cnt_w(BLANK_TICKS);
         localparam logic [W-1:0] LIM = W'(BLANK_TICKS);
         logic hold, done, trip_q;

         assign hold = arm & flt_oc;

         rrs_tick_count #(.W(W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (~hold | trip_q),
            .tick  (tick),
            .limit (LIM),
            .done  (done)
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     trip_q <= 1'b0;
            else if (!hold) trip_q <= 1'b0;
            else if (done)  trip_q <= 1'b1;
         end

         assign trip = trip_q;
      end
   endgenerate
endmodule

// File: rtl/rrs_pgood.sv
// Power-good with a long assert qualification and a short loss filter.
module rrs_pgood #(
   parameter int unsigned ON_TICKS  = 300,
   parameter int unsigned OFF_TICKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic running,
   input  logic in_reg,
   output logic pgood_n
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned W_ON = rrs_pkg::cnt_w(ON_TICKS);
   localparam logic [W_ON-1:0] LIM_ON = W_ON'(ON_TICKS);

   generate
      if (ON_TICKS < 1) begin : g_bad_on
         $error("rrs_pgood: ON_TICKS must be at least 1");
      end
   endgenerate

   logic pg_q, good, on_done, drop;

   assign good = running & in_reg;

   rrs_tick_count #(.W(W_ON)) u_on (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (~good | pg_q),
      .tick  (tick),
      .limit (LIM_ON),
      .done  (on_done)
   );

   generate
      if (OFF_TICKS == 0) begin : g_fast
         assign drop = ~in_reg;
      end else begin : g_filt
         localparam int unsigned W_OFF = rrs_pkg::cnt_w(OFF_TICKS);
         localparam logic [W_OFF-1:0] LIM_OFF = W_OFF'(OFF_TICKS);
         logic off_done;

         rrs_tick_count #(.W(W_OFF)) u_off (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (~(pg_q & ~in_reg)),
            .tick  (tick),
            .limit (LIM_OFF),
            .done  (off_done)
         );

         assign drop = off_done & ~in_reg;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pg_q <= 1'b0;
      else if (!running)         pg_q <= 1'b0;
      else if (drop)             pg_q <= 1'b0;
      else if (on_done && good)  pg_q <= 1'b1;
   end

   assign pgood_n = ~(pg_q & running);
endmodule

// File: rtl/rrs_fsm.sv
// Sequencing and retry state machine.
module rrs_fsm #(
   parameter int unsigned ON_DLY_TICKS = 200,
   parameter int unsigned EN_OFF_TICKS = 50,
   parameter int unsigned OFF_TICKS    = 10000,
   parameter int unsigned MAX_RETRY    = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic en_n,
   input  logic src_ok,
   input  logic flt_ov,
   input  logic flt_ot,
   input  logic flt_uv,
   input  logic oc_trip,
   input  logic in_reg,
   output logic out_en,
   output logic running,
   output logic latched
);
   timeunit 1ns;
   timeprecision 1ps;
   import rrs_pkg::*;

   localparam int unsigned TW = cnt_w(max3(ON_DLY_TICKS, EN_OFF_TICKS, OFF_TICKS));
   localparam int unsigned RW = cnt_w(MAX_RETRY);
   localparam logic [RW-1:0] RLIM = RW'(MAX_RETRY);

   generate
      if (ON_DLY_TICKS < 1 || EN_OFF_TICKS < 1 || OFF_TICKS < 1) begin : g_bad_dly
         $error("rrs_fsm: every delay must be at least one tick");
      end
   endgenerate

   rrs_state_e   st_q, st_d;
   logic [RW-1:0] rc_q;
   logic [TW-1:0] t_limit;
   logic          timed, t_done, on_q, on_d, uv_armed_q, trip, at_limit;

   assign on_q     = (st_q == ST_RUN) || (st_q == ST_OFFDLY);
   assign on_d     = (st_d == ST_RUN) || (st_d == ST_OFFDLY);
   assign timed    = (st_q == ST_ONDLY) || (st_q == ST_OFFDLY) || (st_q == ST_COOL);
   assign at_limit = (rc_q == RLIM);
   assign trip     = flt_ov | flt_ot | oc_trip | (flt_uv & uv_armed_q);

   always_comb begin
      unique case (st_q)
         ST_ONDLY:  t_limit = TW'(ON_DLY_TICKS);
         ST_OFFDLY: t_limit = TW'(EN_OFF_TICKS);
         ST_COOL:   t_limit = TW'(OFF_TICKS);
         default:   t_limit = TW'(1);
      endcase
   end

   rrs_tick_count #(.W(TW)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_d != st_q),
      .tick  (tick & timed),
      .limit (t_limit),
      .done  (t_done)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:   if (!en_n) st_d = ST_ONDLY;
         ST_ONDLY:  if (en_n) st_d = ST_IDLE;
                    else if (t_done) st_d = ST_RUN;
         ST_RUN:    if (trip) st_d = at_limit ? ST_LATCH : ST_COOL;
                    else if (en_n) st_d = ST_OFFDLY;
         ST_OFFDLY: if (trip || t_done) st_d = ST_IDLE;
         ST_COOL:   if (en_n) st_d = ST_IDLE;
                    else if (t_done) st_d = ST_RUN;
         ST_LATCH:  if (en_n) st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
      if (!src_ok) st_d = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         rc_q       <= '0;
         uv_armed_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_d == ST_IDLE)
            rc_q <= '0;
         else if (st_q == ST_RUN && st_d == ST_COOL)
            rc_q <= rc_q + RW'(1);
         uv_armed_q <= on_d & (uv_armed_q | (on_q & in_reg));
      end
   end

   assign out_en  = on_q;
   assign running = (st_q == ST_RUN);
   assign latched = (st_q == ST_LATCH);
endmodule

// File: rtl/rail_retry_supervisor.sv
module rail_retry_supervisor #(
   parameter int unsigned ON_DLY_TICKS   = 200,
   parameter int unsigned EN_OFF_TICKS   = 50,
   parameter int unsigned OFF_TICKS      = 10000,
   parameter int unsigned OC_BLANK_TICKS = 22,
   parameter int unsigned PG_ON_TICKS    = 300,
   parameter int unsigned PG_OFF_TICKS   = 3,
   parameter int unsigned MAX_RETRY      = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic en_n,
   input  logic src_ok,
   input  logic flt_ov,
   input  logic flt_oc,
   input  logic flt_uv,
   input  logic flt_ot,
   input  logic in_reg,
   output logic out_en,
   output logic pgood_n,
   output logic fault_latched
);
   timeunit 1ns;
   timeprecision 1ps;

   logic running, oc_trip;

   rrs_oc_blank #(.BLANK_TICKS(OC_BLANK_TICKS)) u_oc (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (ms_tick),
      .arm    (running),
      .flt_oc (flt_oc),
      .trip   (oc_trip)
   );

   rrs_fsm #(
      .ON_DLY_TICKS (ON_DLY_TICKS),
      .EN_OFF_TICKS (EN_OFF_TICKS),
      .OFF_TICKS    (OFF_TICKS),
      .MAX_RETRY    (MAX_RETRY)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (ms_tick),
      .en_n    (en_n),
      .src_ok  (src_ok),
      .flt_ov  (flt_ov),
      .flt_ot  (flt_ot),
      .flt_uv  (flt_uv),
      .oc_trip (oc_trip),
      .in_reg  (in_reg),
      .out_en  (out_en),
      .running (running),
      .latched (fault_latched)
   );

   rrs_pgood #(.ON_TICKS(PG_ON_TICKS), .OFF_TICKS(PG_OFF_TICKS)) u_pg (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (ms_tick),
      .running (running),
      .in_reg  (in_reg),
      .pgood_n (pgood_n)
   );
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker (
   input logic clk,
   input logic rst_n,
   input logic en_n,
   input logic src_ok,
   input logic flt_ov,
   input logic flt_ot,
   input logic out_en,
   input logic pgood_n,
   input logic fault_latched
);
   timeunit 1ns;
   timeprecision 1ps;

   AST_NOSRC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !src_ok |=> !out_en);  // R13

   AST_PG_NEEDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      !pgood_n |-> out_en);  // R12

   AST_LATCH_OUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      fault_latched |-> !out_en);  // R6

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_latched && src_ok && !en_n) |=> fault_latched);  // R6

   AST_LATCH_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_latched) |-> $past(out_en));  // R6

   AST_HARD_FAULT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en && (flt_ov || flt_ot)) |=> !out_en);  // R4

   AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_en) |-> ($past(!en_n) && $past(src_ok)));  // R2
endmodule

bind rail_retry_supervisor rrs_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .en_n          (en_n),
   .src_ok        (src_ok),
   .flt_ov        (flt_ov),
   .flt_ot        (flt_ot),
   .out_en        (out_en),
   .pgood_n       (pgood_n),
   .fault_latched (fault_latched)
);

// File: tb/rail_retry_supervisor_tb.sv
module rail_retry_supervisor_tb;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned T_ON    = 4;
   localparam int unsigned T_ENOFF = 2;
   localparam int unsigned T_OFF   = 6;
   localparam int unsigned T_BLANK = 3;
   localparam int unsigned T_PGON  = 5;
   localparam int unsigned T_PGOFF = 2;
   localparam int unsigned T_RETRY = 5;

   // {fault kind[1:0], expect lock-off}; kind 0 ov, 1 ot, 2 uv, 3 oc
   localparam logic [2:0] FAULT_VEC [6] = '{3'b000, 3'b010, 3'b100, 3'b110, 3'b000, 3'b011};

   logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0, en_n = 1'b1, src_ok = 1'b0;
   logic flt_ov = 1'b0, flt_oc = 1'b0, flt_uv = 1'b0, flt_ot = 1'b0, in_reg = 1'b0;
   logic out_en, pgood_n, fault_latched;
   int   n_chk = 0, n_fail = 0;
   logic fin = 1'b0;

   always #5 clk = ~clk;

   rail_retry_supervisor #(
      .ON_DLY_TICKS (T_ON), .EN_OFF_TICKS (T_ENOFF), .OFF_TICKS (T_OFF),
      .OC_BLANK_TICKS (T_BLANK), .PG_ON_TICKS (T_PGON), .PG_OFF_TICKS (T_PGOFF),
      .MAX_RETRY (T_RETRY)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .ms_tick (ms_tick), .en_n (en_n), .src_ok (src_ok),
      .flt_ov (flt_ov), .flt_oc (flt_oc), .flt_uv (flt_uv), .flt_ot (flt_ot),
      .in_reg (in_reg), .out_en (out_en), .pgood_n (pgood_n), .fault_latched (fault_latched)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tk();
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic power_up();
      en_n = 1'b0;
      src_ok = 1'b1;
      step(2);
      repeat (T_ON) tk();
      in_reg = 1'b1;
      step(2);
      chk("R2", "out_en after turn-on delay", out_en, 1'b1);
   endtask

   task automatic hit(input logic [1:0] kind);
      case (kind)
         2'd0: flt_ov = 1'b1;
         2'd1: flt_ot = 1'b1;
         2'd2: flt_uv = 1'b1;
         default: flt_oc = 1'b1;
      endcase
      if (kind == 2'd3) repeat (T_BLANK) tk();
      else step(1);
      flt_ov = 1'b0; flt_ot = 1'b0; flt_uv = 1'b0; flt_oc = 1'b0;
   endtask

   task automatic short_oc();
      flt_oc = 1'b1;
      repeat (T_BLANK - 1) tk();
      flt_oc = 1'b0;
      step(1);
      chk("R8", "out_en after short overcurrent", out_en, 1'b1);
   endtask

   task automatic walk_table();
      for (int i = 0; i < 6; i++) begin
         hit(FAULT_VEC[i][2:1]);
         chk("R4", "out_en after fault", out_en, 1'b0);
         chk("R12", "pgood_n after fault", pgood_n, 1'b1);
         chk("R6", "fault_latched after fault", fault_latched, FAULT_VEC[i][0]);
         if (!FAULT_VEC[i][0]) begin
            repeat (T_OFF - 1) tk();
            chk("R5", "out_en before cool-down ends", out_en, 1'b0);
            tk();
            chk("R5", "out_en after cool-down", out_en, 1'b1);
            step(2);
         end else begin
            repeat (T_OFF + 2) tk();
            chk("R6", "out_en while locked off", out_en, 1'b0);
            chk("R6", "fault_latched held", fault_latched, 1'b1);
         end
      end
   endtask

   initial begin
      step(3);
      chk("R1", "out_en in reset", out_en, 1'b0);
      chk("R1", "pgood_n in reset", pgood_n, 1'b1);
      chk("R1", "fault_latched in reset", fault_latched, 1'b0);
      rst_n = 1'b1;
      step(1);
      chk("R1", "out_en after reset", out_en, 1'b0);

      // R2: request, abort, request again
      src_ok = 1'b1;
      en_n = 1'b0;
      step(2);
      repeat (2) tk();
      en_n = 1'b1;
      step(2);
      chk("R2", "out_en after aborted request", out_en, 1'b0);
      en_n = 1'b0;
      step(2);
      repeat (T_ON - 1) tk();
      chk("R2", "out_en one tick early", out_en, 1'b0);
      chk("R12", "pgood_n during turn-on delay", pgood_n, 1'b1);
      tk();
      chk("R2", "out_en at turn-on delay", out_en, 1'b1);

      // R9: undervoltage before regulation is ignored
      flt_uv = 1'b1;
      step(3);
      chk("R9", "out_en with unarmed undervoltage", out_en, 1'b1);
      flt_uv = 1'b0;
      chk("R10", "pgood_n without regulation", pgood_n, 1'b1);

      // R10 / R11: power-good delays
      in_reg = 1'b1;
      step(2);
      repeat (T_PGON - 1) tk();
      chk("R10", "pgood_n one tick early", pgood_n, 1'b1);
      tk();
      chk("R10", "pgood_n asserted", pgood_n, 1'b0);
      in_reg = 1'b0;
      step(1);
      repeat (T_PGOFF - 1) tk();
      chk("R11", "pgood_n in loss filter", pgood_n, 1'b0);
      in_reg = 1'b1;
      step(1);
      tk();
      in_reg = 1'b0;
      step(1);
      repeat (T_PGOFF - 1) tk();
      chk("R11", "pgood_n after filter restart", pgood_n, 1'b0);
      tk();
      chk("R11", "pgood_n deasserted", pgood_n, 1'b1);
      in_reg = 1'b1;

      // R3: turn-off hold
      en_n = 1'b1;
      step(2);
      chk("R3", "out_en held after release", out_en, 1'b1);
      chk("R12", "pgood_n in turn-off delay", pgood_n, 1'b1);
      repeat (T_ENOFF - 1) tk();
      chk("R3", "out_en one tick before off", out_en, 1'b1);
      tk();
      chk("R3", "out_en after turn-off delay", out_en, 1'b0);

      // pass 0: lock-off, cleared by loss of input power
      power_up();
      short_oc();
      walk_table();
      src_ok = 1'b0;
      step(1);
      chk("R7", "fault_latched after source loss", fault_latched, 1'b0);
      chk("R13", "out_en after source loss", out_en, 1'b0);

      // pass 1: full budget again, cleared by enable toggle
      power_up();
      short_oc();
      walk_table();
      en_n = 1'b1;
      step(2);
      chk("R7", "fault_latched after enable toggle", fault_latched, 1'b0);
      power_up();

      // R13: source loss while running
      src_ok = 1'b0;
      step(1);
      chk("R13", "out_en after source loss while running", out_en, 1'b0);
      chk("R12", "pgood_n after source loss", pgood_n, 1'b1);

      fin = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!fin) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule